// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins. Each pin passes through a synchronizer and then an edge or level detector. A per-pin sense code selects what the detector looks for. A detected event sets a pending flag for that pin. The flag stays set until software clears it.

Each pending flag is gated before it reaches an output. The gate needs a per-pin mask bit that is clear and a per-pin priority field that is nonzero. The block drives one interrupt line per pin and one line that is the OR of all of them. A system that routes every pin to one shared parent input uses the OR line.

Software programs the block through a simple synchronous register bus with read and write strobes. Pins are numbered from the most significant end of every register. A control register holds a mode bit that selects individual-pin operation for the surrounding system.

Top module: `ext_irq_pin_ctrl`

## Requirements
- R1: After reset, all outputs are low. The sense, priority, control and pending registers read as zero, and every pin is masked. A pin that becomes pending before it is unmasked therefore drives no output.
- R2: Each pin has a sense field of SENSE_W bits (default 4) in the sense register at address 0. The field for pin n has its lowest bit at position 32-(n+1)*SENSE_W, so pin 0 holds the top field. The codes are: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges. Any other code never sets the pending flag.
- R3: In the edge modes, a pin sets its pending flag only on a matching transition of its synchronized value. The pin's outputs rise no later than three clock edges after the pin changes. A rising-edge event is never followed by another event in the next cycle.
- R4: In the level modes, the pending flag is set again on every cycle in which the pin is at its active level. A clear write therefore has no lasting effect while that level holds. The clear works once the level is gone.
- R5: The pending register is at address 2, with pin n at bit 7-n in read data bits [7:0]. A written bit of 0 clears that pin's flag. A written bit of 1 leaves the flag unchanged. A new event in the same cycle as a clear wins over the clear.
- R6: A write to address 3 masks every pin whose bit (pin n at bit 7-n) is 1. A write to address 4 unmasks every pin whose bit is 1. Bits written as 0 change nothing. Pending flags keep latching while a pin is masked. Both addresses read as zero.
- R7: The priority register is at address 1. Pin n has a 4-bit field with its lowest bit at 32-(n+1)*4. A field of 0 blocks the pin's output, and any nonzero value lets it through.
- R8: The output for pin n is high exactly when the pin is pending, unmasked and has a nonzero priority field. The combined output is the OR of all per-pin outputs, so a masked pending pin does not contribute to it.
- R9: The control register at address 5 stores all 32 written bits and reads them back. The individual-mode output follows bit 23 of this register.
- R10: Read data is registered. It is valid in the cycle after the read strobe and holds until the next read. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous interrupt pins, bit n is pin n |
| irq_out | output | NUM_PINS | Per-pin gated interrupt, bit n is pin n |
| irq_any | output | 1 | OR of all per-pin interrupts |
| indiv_mode | output | 1 | Individual-pin mode bit from the control register |

## Verification
The bench builds the block with its default parameters: eight pins and 4-bit sense fields. This makes all five sense codes reachable, including both-edge mode, which does not fit in a 2-bit field. Eight pins put pin 0 in the top field of each 32-bit register and pin 7 in the bottom one. The tests use pins spread across the word, so a mistake in the reversed numbering or in a field offset shows up as the wrong pin responding. The bench also drives invalid sense codes 5 and 15, and it holds level pins active through a clear to reach the level-mode corner case.

// File: rtl/eip_pkg.sv
// Shared constants for the external interrupt pin controller.
// Assumes a 3-bit register address and 4-bit sense code space.
package eip_pkg;
    localparam int ADDR_W = 3;
    localparam int CODE_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_SENSE = 3'd0,
        A_PRIO  = 3'd1,
        A_SRC   = 3'd2,
        A_MSET  = 3'd3,
        A_MCLR  = 3'd4,
        A_CTRL  = 3'd5
    } reg_addr_e;

    typedef enum logic [CODE_W-1:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;
endpackage

// File: rtl/eip_pin_detect.sv
// One pin: two-flop synchronizer, a history flop, and the event decode.
// Assumes the sense code is stable software state. Unknown codes give no event.
module eip_pin_detect
    import eip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_async,
    input  logic [CODE_W-1:0] code,
    output logic              evt
);
    logic [1:0] sync_q;
    logic       hist_q;
    logic       cur;

    // Synchronize the pin and keep the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_async};
            hist_q <= sync_q[1];
        end
    end

    assign cur = sync_q[1];

    // Decode an event from the sense code and the synchronized history.
    always_comb begin
        case (code)
            SNS_FALL: evt = hist_q & ~cur;
            SNS_RISE: evt = ~hist_q & cur;
            SNS_LOW:  evt = ~cur;
            SNS_HIGH: evt = cur;
            SNS_BOTH: evt = hist_q ^ cur;
            default:  evt = 1'b0;
        endcase
    end

    // R3
    rise_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && code == SNS_RISE) |=> (code != SNS_RISE) || !evt);
endmodule

// File: rtl/eip_irq_gate.sv
// One pin's output gate: pending, not masked, and a nonzero priority field.
// Assumes all inputs come from registers, so the output is glitch-safe per cycle.
module eip_irq_gate #(
    parameter int PRIO_W = 4
) (
    input  logic              pend,
    input  logic              masked,
    input  logic [PRIO_W-1:0] prio,
    output logic              irq
);
    // Combine the three qualifiers.
    always_comb irq = pend & ~masked & (|prio);
endmodule

// File: rtl/eip_regfile.sv
// Register file: sense, priority and control words, the mask bits and the pending flags.
// Assumes one bus access per cycle. Pin n maps to bit SRC_W-1-n of the source and mask registers.
module eip_regfile
    import eip_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int REG_W    = 32,
    parameter int SRC_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0] pin_evt,
    output logic [REG_W-1:0]  sense_word,
    output logic [REG_W-1:0]  prio_word,
    output logic [REG_W-1:0]  ctrl_word,
    output logic [NUM_PINS-1:0] pend,
    output logic [NUM_PINS-1:0] mask
);
    logic [REG_W-1:0] sense_q, prio_q, ctrl_q, rdata_q, src_view;
    logic [NUM_PINS-1:0] pend_q, mask_q;
    logic wr_src, wr_mset, wr_mclr;

    assign wr_src  = bus_wr && (bus_addr == A_SRC);
    assign wr_mset = bus_wr && (bus_addr == A_MSET);
    assign wr_mclr = bus_wr && (bus_addr == A_MCLR);

    // Full-word software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
            ctrl_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_SENSE) sense_q <= bus_wdata;
            if (bus_addr == A_PRIO)  prio_q  <= bus_wdata;
            if (bus_addr == A_CTRL)  ctrl_q  <= bus_wdata;
        end
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int BIT = SRC_W - 1 - n;

        // Mask bit: write-one-to-set at one address, write-one-to-clear at another.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[n] <= 1'b1;
            else if (wr_mset && bus_wdata[BIT])
                mask_q[n] <= 1'b1;
            else if (wr_mclr && bus_wdata[BIT])
                mask_q[n] <= 1'b0;
        end

        // Pending flag: a zero written clears it, and a new event wins over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[n] <= 1'b0;
            else
                pend_q[n] <= (pend_q[n] & ~(wr_src & ~bus_wdata[BIT])) | pin_evt[n];
        end

        // R5
        pend_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_q[n]) |-> $past(wr_src && !bus_wdata[BIT]));
        // R2
        pend_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[n]) |-> $past(pin_evt[n]));
        // R6
        mask_rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mask_q[n]) |-> $past(wr_mset && bus_wdata[BIT]));
        // R6
        mask_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mask_q[n]) |-> $past(wr_mclr && bus_wdata[BIT]));
    end

    // Pending flags as software sees them, reversed numbering, zero-extended.
    always_comb begin
        src_view = '0;
        for (int n = 0; n < NUM_PINS; n++)
            src_view[SRC_W-1-n] = pend_q[n];
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                A_SENSE: rdata_q <= sense_q;
                A_PRIO:  rdata_q <= prio_q;
                A_SRC:   rdata_q <= src_view;
                A_CTRL:  rdata_q <= ctrl_q;
                default: rdata_q <= '0;
            endcase
        end
    end

    // R10
    src_read_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == A_SRC) |-> (bus_rdata == $past(src_view)));

    assign bus_rdata  = rdata_q;
    assign sense_word = sense_q;
    assign prio_word  = prio_q;
    assign ctrl_word  = ctrl_q;
    assign pend       = pend_q;
    assign mask       = mask_q;
endmodule

// File: rtl/ext_irq_pin_ctrl.sv
// Top level: per-pin detectors and gates around the register file.
// Assumes NUM_PINS*SENSE_W and NUM_PINS*4 fit in REG_W, and SENSE_W is 2 or 4.
module ext_irq_pin_ctrl
    import eip_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int MODE_BIT = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] irq_out,
    output logic                irq_any,
    output logic                indiv_mode
);
    localparam int REG_W  = 32;
    localparam int SRC_W  = 8;
    localparam int PRIO_W = 4;

    logic [REG_W-1:0]    sense_word, prio_word, ctrl_word;
    logic [NUM_PINS-1:0] pend, mask, pin_evt, irq_vec;

    eip_regfile #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_evt(pin_evt),
        .sense_word(sense_word), .prio_word(prio_word), .ctrl_word(ctrl_word),
        .pend(pend), .mask(mask)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int SNS_LSB = REG_W - (n + 1) * SENSE_W;
        localparam int PRI_LSB = REG_W - (n + 1) * PRIO_W;
        logic [CODE_W-1:0] code;

        // Zero-extend this pin's sense field to a full code.
        always_comb begin
            code = '0;
            code[SENSE_W-1:0] = sense_word[SNS_LSB +: SENSE_W];
        end

        eip_pin_detect u_det (
            .clk(clk), .rst_n(rst_n), .pin_async(pin_in[n]),
            .code(code), .evt(pin_evt[n])
        );

        eip_irq_gate #(.PRIO_W(PRIO_W)) u_gate (
            .pend(pend[n]), .masked(mask[n]),
            .prio(prio_word[PRI_LSB +: PRIO_W]), .irq(irq_vec[n])
        );

        // R8
        masked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(bus_wr && bus_addr == A_MSET && bus_wdata[SRC_W-1-n]) |-> !irq_out[n]);
    end

    assign irq_out    = irq_vec;
    assign irq_any    = |irq_vec;
    assign indiv_mode = ctrl_word[MODE_BIT];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_any == 1'b0));
endmodule

// File: tb/ext_irq_pin_ctrl_tb.sv
module ext_irq_pin_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  irq_out;
    logic        irq_any, indiv_mode;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_irq_pin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out), .irq_any(irq_any), .indiv_mode(indiv_mode)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_pins(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        settle();
    endtask

    task automatic cleanup();
        wr(3'd0, 32'h0);
        set_pins(8'h00);
        wr(3'd2, 32'h0);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_out", {24'h0, irq_out}, 32'h0);
        chk("R1 irq_any", {31'h0, irq_any}, 32'h0);
        rd(3'd2, d); chk("R1 source", d, 32'h0);
        rd(3'd0, d); chk("R1 sense", d, 32'h0);
        rd(3'd1, d); chk("R1 prio", d, 32'h0);
        rd(3'd5, d); chk("R1 ctrl", d, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0001);
        set_pins(8'h80);
        rd(3'd2, d); chk("R1 pend while masked", d, 32'h01);
        chk("R1 masked at reset", {24'h0, irq_out}, 32'h0);
        wr(3'd4, 32'hFF);
        settle();
        chk("R1 after unmask", {24'h0, irq_out}, 32'h80);
        chk("R1 any after unmask", {31'h0, irq_any}, 32'h1);
        cleanup();
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(3'd0, 32'h1234_5678); rd(3'd0, d); chk("R10 sense readback", d, 32'h1234_5678);
        wr(3'd1, 32'hA5A5_A5A5); rd(3'd1, d); chk("R10 prio readback", d, 32'hA5A5_A5A5);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0080_0000);
        settle();
        chk("R9 mode on", {31'h0, indiv_mode}, 32'h1);
        rd(3'd5, d); chk("R9 ctrl readback", d, 32'h0080_0000);
        wr(3'd5, d | 32'h1); rd(3'd5, d); chk("R9 rmw keeps", d, 32'h0080_0001);
        chk("R9 mode kept", {31'h0, indiv_mode}, 32'h1);
        wr(3'd5, 32'h1);
        settle();
        chk("R9 mode off", {31'h0, indiv_mode}, 32'h0);
        rd(3'd3, d); chk("R6 mask set reads 0", d, 32'h0);
        rd(3'd4, d); chk("R6 mask clr reads 0", d, 32'h0);
        rd(3'd7, d); chk("R10 unmapped", d, 32'h0);
        rd(3'd6, d); chk("R10 unmapped 6", d, 32'h0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [31:0] d;
        set_pins(8'h01);
        rd(3'd2, d); chk("R3 no event on rise in fall mode", d, 32'h0);
        set_pins(8'h00);
        rd(3'd2, d); chk("R2 fall pin0 top bit", d, 32'h80);
        chk("R8 irq pin0", {24'h0, irq_out}, 32'h01);
        wr(3'd2, 32'h7F);
        rd(3'd2, d); chk("R5 clear pin0", d, 32'h0);
        cleanup();
    endtask

    task automatic t_rise_both();
        logic [31:0] d;
        wr(3'd0, 32'h0000_0001);
        set_pins(8'h80);
        rd(3'd2, d); chk("R3 rise pin7", d, 32'h01);
        wr(3'd2, 32'h0);
        set_pins(8'h00);
        rd(3'd2, d); chk("R3 no fall event in rise mode", d, 32'h0);
        wr(3'd0, 32'h0004_0000);
        set_pins(8'h08);
        rd(3'd2, d); chk("R3 both rise pin3", d, 32'h10);
        wr(3'd2, 32'h0);
        set_pins(8'h00);
        rd(3'd2, d); chk("R3 both fall pin3", d, 32'h10);
        cleanup();
    endtask

    task automatic t_src_keep();
        logic [31:0] d;
        set_pins(8'h09);
        set_pins(8'h00);
        rd(3'd2, d); chk("R5 two pending", d, 32'h90);
        wr(3'd2, 32'hFF);
        rd(3'd2, d); chk("R5 ones keep", d, 32'h90);
        wr(3'd2, 32'hEF);
        rd(3'd2, d); chk("R5 clear pin3 only", d, 32'h80);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(3'd0, 32'h0000_0300);
        set_pins(8'h20);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk("R4 high level refills", d, 32'h04);
        set_pins(8'h00);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk("R4 clear after level gone", d, 32'h0);
        wr(3'd0, 32'h0000_0020);
        settle();
        rd(3'd2, d); chk("R4 low level pending", d, 32'h02);
        set_pins(8'h40);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk("R4 low level cleared", d, 32'h0);
        cleanup();
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        wr(3'd0, 32'hF500_0000);
        set_pins(8'h03);
        set_pins(8'h00);
        rd(3'd2, d); chk("R2 invalid codes ignored", d, 32'h0);
        cleanup();
    endtask

    task automatic t_mask_prio();
        logic [31:0] d;
        wr(3'd0, 32'h0010_0001);
        wr(3'd3, 32'h20);
        set_pins(8'h04);
        rd(3'd2, d); chk("R6 pend latched while masked", d, 32'h20);
        chk("R6 masked output", {24'h0, irq_out}, 32'h0);
        chk("R8 masked not in any", {31'h0, irq_any}, 32'h0);
        wr(3'd4, 32'h00); settle();
        chk("R6 zero clear no effect", {24'h0, irq_out}, 32'h0);
        wr(3'd4, 32'h20); settle();
        chk("R6 unmask", {24'h0, irq_out}, 32'h04);
        wr(3'd3, 32'h00); settle();
        chk("R6 zero set no effect", {24'h0, irq_out}, 32'h04);
        wr(3'd3, 32'h04); settle();
        chk("R6 other pin mask", {24'h0, irq_out}, 32'h04);
        wr(3'd4, 32'h04);
        wr(3'd1, 32'hFF0F_FFFF); settle();
        chk("R7 prio zero blocks", {24'h0, irq_out}, 32'h0);
        wr(3'd1, 32'h0010_0000); settle();
        chk("R7 prio nonzero passes", {24'h0, irq_out}, 32'h04);
        wr(3'd1, 32'hFFFF_FFFF);
        set_pins(8'h84);
        chk("R8 two pins", {24'h0, irq_out}, 32'h84);
        wr(3'd3, 32'h20); settle();
        chk("R8 any from pin7", {31'h0, irq_any}, 32'h1);
        wr(3'd3, 32'h01); settle();
        chk("R8 any low when all masked", {31'h0, irq_any}, 32'h0);
        wr(3'd4, 32'hFF);
        cleanup();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_fall();
        t_rise_both();
        t_src_keep();
        t_level();
        t_invalid();
        t_mask_prio();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule